// File: doc/BRIEF.md
# Line Clamp and Blanking Pulse Generator

This block produces the three per-line timing strobes that an image sensor front end needs around each horizontal line: an active-low black-level clamp strobe, an active-low pre-blank strobe and an active-high horizontal blanking window. All three are placed by positions on a 12-bit pixel counter. The counter restarts a fixed number of clocks after the falling edge of the line sync. Once it reaches its top value it holds there.

Up to ten pattern slots are presented on the inputs. A slot select input picks the slot that drives the outputs in each cycle. The blanking window can switch on and off several times in one line, and it can use different toggle groups on odd and even lines. While blanking is active, the block overrides the four horizontal clock outputs to fixed levels. Outside blanking, the horizontal clocks pass through as two complementary pairs.

Top module: `line_blank_gen`

## Requirements
- R1: A line sync falling edge (`hd_ni` sampled high, then low on the next rising clock edge) restarts the pixel counter at 0, 17 rising edges after the edge that sampled the low level. Each output reflects pixel position k one rising edge after the counter holds k.
- R2: Clamp and pre-blank each begin the line at their start-polarity bit. Their level inverts once for each of their two toggle positions that the pixel position has reached (position >= toggle).
- R3: A toggle value of 4095 never takes effect. The counter stops at 4095 and stays there until the next restart, so outputs hold their last level.
- R4: The blanking output is low at pixel 0 unless a toggle equals 0. It inverts at every enabled toggle (1..6) that the pixel position has reached.
- R5: With the 2-bit alternation code at 0, all six blanking toggles are enabled. With code 1, odd lines (`odd_line_i`=1) use toggles 1-2 and even lines use toggles 3-6. Codes 2 and 3 swap the odd and even assignment.
- R6: While the blanking output is high, `h1_o` and `h3_o` equal the slot's mask bit and `h2_o` and `h4_o` equal its inverse. Otherwise `h1_o`=`h1_src_i`, `h3_o`=`h3_src_i`, `h2_o`=~`h1_src_i` and `h4_o`=~`h3_src_i`.
- R7: `seq_sel_i` picks slot 0..9 in the same cycle the output register loads. A select value of 10 or more uses slot 0.
- R8: During reset `clpob_no`=1, `pblk_no`=1 and `hblk_o`=0, and the counter sits at 4095.
- R9: A new sync falling edge that arrives while a restart is pending restarts the 17-clock lag from the new edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hd_ni | input | 1 | Line sync, active low |
| odd_line_i | input | 1 | 1 on odd lines |
| seq_sel_i | input | 4 | Active slot select |
| h1_src_i | input | 1 | Horizontal clock phase A source |
| h3_src_i | input | 1 | Horizontal clock phase B source |
| clpob_spol_i | input | 10 | Clamp start polarity per slot |
| clpob_tog1_i | input | 10x12 | Clamp first toggle per slot |
| clpob_tog2_i | input | 10x12 | Clamp second toggle per slot |
| pblk_spol_i | input | 10 | Pre-blank start polarity per slot |
| pblk_tog1_i | input | 10x12 | Pre-blank first toggle per slot |
| pblk_tog2_i | input | 10x12 | Pre-blank second toggle per slot |
| hblk_tog_i | input | 10x6x12 | Blanking toggles 1..6 per slot (index 0 = toggle 1) |
| hblk_alt_i | input | 10x2 | Odd/even alternation code per slot |
| hblk_mask_i | input | 10 | Level of phase A clocks during blanking per slot |
| clpob_no | output | 1 | Clamp strobe, active low |
| pblk_no | output | 1 | Pre-blank strobe, active low |
| hblk_o | output | 1 | Blanking window, active high |
| h1_o | output | 1 | Horizontal clock 1 |
| h2_o | output | 1 | Horizontal clock 2 |
| h3_o | output | 1 | Horizontal clock 3 |
| h4_o | output | 1 | Horizontal clock 4 |

## Verification
The bench builds the block with its defaults: a 12-bit counter, ten slots and a 17-clock restart lag. Because 4096 cycles is cheap to run, one long line drives the counter into its hold state and shows that toggles at 4095 stay inert. Random lines mix select values above the slot count, all four alternation codes, odd and even lines, and sync edges that come back within the lag window.

// File: rtl/lbg_pkg.sv
package lbg_pkg;
  localparam int unsigned N_HTOG = 6;

  typedef enum logic [1:0] {
    ALT_OFF  = 2'd0,
    ALT_ODDA = 2'd1,
    ALT_EVNA = 2'd2,
    ALT_EVNB = 2'd3
  } alt_e;

  // bit k enables toggle k+1; group A = toggles 1-2, group B = toggles 3-6
  function automatic logic [N_HTOG-1:0] hblk_en(input logic [1:0] alt, input logic odd);
    logic use_a;
    if (alt_e'(alt) == ALT_OFF) return '1;
    use_a = (alt_e'(alt) == ALT_ODDA) ? odd : ~odd;
    return use_a ? 6'b000011 : 6'b111100;
  endfunction
endpackage

// File: rtl/lbg_line_cnt.sv
module lbg_line_cnt #(
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned HD_LAG = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hd_ni,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int unsigned LAG_W = $clog2(HD_LAG + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             hd_prev_q, pend_q, hd_fall, load;
  logic [LAG_W-1:0] lag_q;
  logic [CNT_W-1:0] cnt_q;

  assign hd_fall = hd_prev_q & ~hd_ni;
  assign load    = pend_q && (lag_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hd_prev_q <= 1'b1;
      pend_q    <= 1'b0;
      lag_q     <= '0;
      cnt_q     <= CNT_MAX;
    end else begin
      hd_prev_q <= hd_ni;
      if (hd_fall) begin
        pend_q <= 1'b1;
        lag_q  <= LAG_W'(HD_LAG - 1);
      end else if (pend_q) begin
        if (lag_q == '0) pend_q <= 1'b0;
        else             lag_q  <= lag_q - 1'b1;
      end
      if (load)                cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;

  // R9
  lag_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hd_fall |=> (pend_q && lag_q == LAG_W'(HD_LAG - 1)));
  // R1
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R3
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/lbg_tog_level.sv
module lbg_tog_level #(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned N_TOG = 2
) (
  input  logic [CNT_W-1:0]            cnt_i,
  input  logic                        start_i,
  input  logic [N_TOG-1:0][CNT_W-1:0] tog_i,
  input  logic [N_TOG-1:0]            en_i,
  output logic                        level_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // level = start inverted once per reached toggle; all-ones toggle is inert
  always_comb begin
    level_o = start_i;
    for (int k = 0; k < N_TOG; k++) begin
      if (en_i[k] && (tog_i[k] != CNT_MAX) && (cnt_i >= tog_i[k])) level_o = ~level_o;
    end
  end
endmodule

// File: rtl/lbg_slot_mux.sv
module lbg_slot_mux #(
  parameter int unsigned W     = 8,
  parameter int unsigned N     = 10,
  parameter int unsigned SEL_W = 4
) (
  input  logic [N-1:0][W-1:0] slots_i,
  input  logic [SEL_W-1:0]    sel_i,
  output logic [W-1:0]        slot_o
);
  // out-of-range select falls back to slot 0
  always_comb begin
    slot_o = slots_i[0];
    for (int k = 1; k < N; k++) begin
      if (sel_i == SEL_W'(k)) slot_o = slots_i[k];
    end
  end
endmodule

// File: rtl/lbg_h_mask.sv
module lbg_h_mask (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hblk_i,
  input  logic mask_i,
  input  logic h1_src_i,
  input  logic h3_src_i,
  output logic h1_o,
  output logic h2_o,
  output logic h3_o,
  output logic h4_o
);
  assign h1_o = hblk_i ? mask_i : h1_src_i;
  assign h3_o = hblk_i ? mask_i : h3_src_i;
  assign h2_o = ~h1_o;
  assign h4_o = ~h3_o;

  // R6
  h_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h2_o != h1_o) && (h4_o != h3_o));
  // R6
  h_forced_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hblk_i |-> (h1_o == mask_i && h3_o == mask_i));
endmodule

// File: rtl/line_blank_gen.sv
module line_blank_gen
  import lbg_pkg::*;
#(
  parameter int unsigned CNT_W   = 12,
  parameter int unsigned NUM_SEQ = 10,
  parameter int unsigned HD_LAG  = 17,
  localparam int unsigned SEL_W  = (NUM_SEQ > 1) ? $clog2(NUM_SEQ) : 1
) (
  input  logic                                    clk_i,
  input  logic                                    rst_ni,
  input  logic                                    hd_ni,
  input  logic                                    odd_line_i,
  input  logic [SEL_W-1:0]                        seq_sel_i,
  input  logic                                    h1_src_i,
  input  logic                                    h3_src_i,
  input  logic [NUM_SEQ-1:0]                      clpob_spol_i,
  input  logic [NUM_SEQ-1:0][CNT_W-1:0]           clpob_tog1_i,
  input  logic [NUM_SEQ-1:0][CNT_W-1:0]           clpob_tog2_i,
  input  logic [NUM_SEQ-1:0]                      pblk_spol_i,
  input  logic [NUM_SEQ-1:0][CNT_W-1:0]           pblk_tog1_i,
  input  logic [NUM_SEQ-1:0][CNT_W-1:0]           pblk_tog2_i,
  input  logic [NUM_SEQ-1:0][N_HTOG-1:0][CNT_W-1:0] hblk_tog_i,
  input  logic [NUM_SEQ-1:0][1:0]                 hblk_alt_i,
  input  logic [NUM_SEQ-1:0]                      hblk_mask_i,
  output logic                                    clpob_no,
  output logic                                    pblk_no,
  output logic                                    hblk_o,
  output logic                                    h1_o,
  output logic                                    h2_o,
  output logic                                    h3_o,
  output logic                                    h4_o
);
  localparam int unsigned AFE_W   = 2 * CNT_W + 1;
  localparam int unsigned OFF_HT  = 2 * AFE_W;
  localparam int unsigned OFF_ALT = OFF_HT + N_HTOG * CNT_W;
  localparam int unsigned OFF_MSK = OFF_ALT + 2;
  localparam int unsigned SLOT_W  = OFF_MSK + 1;

  logic [NUM_SEQ-1:0][SLOT_W-1:0] slots;
  logic [SLOT_W-1:0]              act;
  logic [CNT_W-1:0]               cnt;
  logic [1:0]                     afe_lvl;
  logic                           hblk_lvl;
  logic [N_HTOG-1:0][CNT_W-1:0]   htog;
  logic [1:0]                     afe_q;
  logic                           hblk_q, mask_q;

  for (genvar s = 0; s < NUM_SEQ; s++) begin : g_slot
    assign slots[s] = {hblk_mask_i[s], hblk_alt_i[s], hblk_tog_i[s],
                       pblk_spol_i[s], pblk_tog2_i[s], pblk_tog1_i[s],
                       clpob_spol_i[s], clpob_tog2_i[s], clpob_tog1_i[s]};
  end

  lbg_slot_mux #(.W(SLOT_W), .N(NUM_SEQ), .SEL_W(SEL_W)) u_mux (
    .slots_i (slots),
    .sel_i   (seq_sel_i),
    .slot_o  (act)
  );

  lbg_line_cnt #(.CNT_W(CNT_W), .HD_LAG(HD_LAG)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hd_ni  (hd_ni),
    .cnt_o  (cnt)
  );

  // k=0 clamp, k=1 pre-blank
  for (genvar k = 0; k < 2; k++) begin : g_afe
    logic [1:0][CNT_W-1:0] tog;
    assign tog = {act[k*AFE_W + CNT_W +: CNT_W], act[k*AFE_W +: CNT_W]};
    lbg_tog_level #(.CNT_W(CNT_W), .N_TOG(2)) u_lvl (
      .cnt_i   (cnt),
      .start_i (act[k*AFE_W + 2*CNT_W]),
      .tog_i   (tog),
      .en_i    (2'b11),
      .level_o (afe_lvl[k])
    );
  end

  assign htog = act[OFF_HT +: N_HTOG*CNT_W];

  lbg_tog_level #(.CNT_W(CNT_W), .N_TOG(N_HTOG)) u_hlvl (
    .cnt_i   (cnt),
    .start_i (1'b0),
    .tog_i   (htog),
    .en_i    (hblk_en(act[OFF_ALT +: 2], odd_line_i)),
    .level_o (hblk_lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      afe_q  <= 2'b11;
      hblk_q <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      afe_q  <= afe_lvl;
      hblk_q <= hblk_lvl;
      mask_q <= act[OFF_MSK];
    end
  end

  assign clpob_no = afe_q[0];
  assign pblk_no  = afe_q[1];
  assign hblk_o   = hblk_q;

  lbg_h_mask u_hmask (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hblk_i   (hblk_q),
    .mask_i   (mask_q),
    .h1_src_i (h1_src_i),
    .h3_src_i (h3_src_i),
    .h1_o     (h1_o),
    .h2_o     (h2_o),
    .h3_o     (h3_o),
    .h4_o     (h4_o)
  );

  // R4
  hblk_line_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == '0 && htog[0] != '0 && htog[1] != '0 && htog[2] != '0 &&
     htog[3] != '0 && htog[4] != '0 && htog[5] != '0) |=> !hblk_o);
endmodule

// File: tb/tb_line_blank_gen.sv
module tb_line_blank_gen;
  localparam int CNT_W = 12, NUM_SEQ = 10, HD_LAG = 17, SEL_W = 4, NT = 6;
  localparam int MAXC = 4095;

  logic clk_i = 1'b0, rst_ni = 1'b0, hd_ni = 1'b1, odd_line_i = 1'b0;
  logic [SEL_W-1:0] seq_sel_i = '0;
  logic h1_src_i = 1'b0, h3_src_i = 1'b0;
  logic [NUM_SEQ-1:0] clpob_spol_i = '0, pblk_spol_i = '0, hblk_mask_i = '0;
  logic [NUM_SEQ-1:0][CNT_W-1:0] clpob_tog1_i = '0, clpob_tog2_i = '0, pblk_tog1_i = '0, pblk_tog2_i = '0;
  logic [NUM_SEQ-1:0][NT-1:0][CNT_W-1:0] hblk_tog_i = '0;
  logic [NUM_SEQ-1:0][1:0] hblk_alt_i = '0;
  logic clpob_no, pblk_no, hblk_o, h1_o, h2_o, h3_o, h4_o;

  int checks = 0, fails = 0;
  logic m_hdp = 1'b1, m_pend = 1'b0;
  int m_lag = 0, m_cnt = MAXC;
  logic e_c = 1'b1, e_p = 1'b1, e_h = 1'b0, e_m = 1'b0;

  always #5 clk_i = ~clk_i;

  line_blank_gen dut (.*);

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic afe_lvl(int c, logic sp, int t1, int t2);
    logic l = sp;
    if (t1 != MAXC && c >= t1) l = ~l;
    if (t2 != MAXC && c >= t2) l = ~l;
    return l;
  endfunction

  function automatic logic hb_lvl(int c, int s, logic odd);
    logic l = 1'b0;
    int alt = hblk_alt_i[s];
    for (int k = 0; k < NT; k++) begin
      logic use_k;
      int t = hblk_tog_i[s][k];
      if (alt == 0) use_k = 1'b1;
      else if (odd == (alt == 1)) use_k = (k < 2);
      else use_k = (k >= 2);
      if (use_k && t != MAXC && c >= t) l = ~l;
    end
    return l;
  endfunction

  // drive at a negedge, advance the model over the next rising edge, check at the following negedge
  task automatic tick(input logic hd, input logic odd, input logic [SEL_W-1:0] sel);
    int s;
    logic load;
    string ta, th;
    hd_ni = hd; odd_line_i = odd; seq_sel_i = sel;
    h1_src_i = 1'($urandom); h3_src_i = 1'($urandom);
    s = (sel < NUM_SEQ) ? int'(sel) : 0;
    ta = (sel >= NUM_SEQ) ? "R7" : ((m_cnt == MAXC) ? "R3" : "R2");
    th = (hblk_alt_i[s] != 0) ? "R5" : "R4";
    e_c = afe_lvl(m_cnt, clpob_spol_i[s], clpob_tog1_i[s], clpob_tog2_i[s]);
    e_p = afe_lvl(m_cnt, pblk_spol_i[s], pblk_tog1_i[s], pblk_tog2_i[s]);
    e_h = hb_lvl(m_cnt, s, odd);
    e_m = hblk_mask_i[s];
    load = m_pend && (m_lag == 0);
    if (load) m_cnt = 0; else if (m_cnt != MAXC) m_cnt++;
    if (m_hdp && !hd) begin m_pend = 1'b1; m_lag = HD_LAG - 1; end
    else if (m_pend) begin if (m_lag == 0) m_pend = 1'b0; else m_lag--; end
    m_hdp = hd;
    @(negedge clk_i);
    chk({ta, " clpob"}, clpob_no, e_c);
    chk({ta, " pblk"}, pblk_no, e_p);
    chk({th, " hblk"}, hblk_o, e_h);
    chk("R6 h1", h1_o, e_h ? e_m : h1_src_i);
    chk("R6 h2", h2_o, e_h ? ~e_m : ~h1_src_i);
    chk("R6 h3", h3_o, e_h ? e_m : h3_src_i);
    chk("R6 h4", h4_o, e_h ? ~e_m : ~h3_src_i);
  endtask

  task automatic run_line(input int len, input int lowc, input logic odd, input logic [SEL_W-1:0] sel);
    for (int i = 0; i < len; i++) tick(i < lowc ? 1'b0 : 1'b1, odd, sel);
  endtask

  function automatic int rtog();
    return ($urandom_range(0, 9) == 0) ? MAXC : int'($urandom_range(0, 130));
  endfunction

  task automatic rand_slots();
    for (int s = 0; s < NUM_SEQ; s++) begin
      clpob_spol_i[s] = 1'($urandom); pblk_spol_i[s] = 1'($urandom);
      hblk_mask_i[s] = 1'($urandom); hblk_alt_i[s] = 2'($urandom);
      clpob_tog1_i[s] = 12'(rtog()); clpob_tog2_i[s] = 12'(rtog());
      pblk_tog1_i[s] = 12'(rtog()); pblk_tog2_i[s] = 12'(rtog());
      for (int k = 0; k < NT; k++) hblk_tog_i[s][k] = 12'(rtog());
    end
  endtask

  initial begin
    #(10ns * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // slot 0: clamp low on pixels 0..19, pre-blank with inert second toggle
    clpob_spol_i[0] = 1'b1; clpob_tog1_i[0] = 12'd0;  clpob_tog2_i[0] = 12'd20;
    pblk_spol_i[0]  = 1'b0; pblk_tog1_i[0]  = 12'd5;  pblk_tog2_i[0]  = 12'd4095;
    hblk_tog_i[0] = {12'd4095, 12'd4095, 12'd40, 12'd30, 12'd8, 12'd3};
    hblk_mask_i[0] = 1'b1; hblk_alt_i[0] = 2'd0;
    repeat (3) @(negedge clk_i);
    // R8 reset state
    chk("R8 clpob", clpob_no, 1'b1);
    chk("R8 pblk", pblk_no, 1'b1);
    chk("R8 hblk", hblk_o, 1'b0);
    rst_ni = 1'b1;
    repeat (5) tick(1'b1, 1'b0, '0);
    // R1: first fall sampled at edge e0; pixel 0 shows after edge e18
    tick(1'b0, 1'b0, '0);
    for (int i = 0; i < 16; i++) tick(1'b1, 1'b0, '0);
    tick(1'b1, 1'b0, '0);
    chk("R1 clpob before restart", clpob_no, 1'b1);
    tick(1'b1, 1'b0, '0);
    chk("R1 clpob at pixel 0", clpob_no, 1'b0);
    run_line(80, 0, 1'b0, '0);
    // R9: second fall inside the lag window
    run_line(6, 1, 1'b1, '0);
    run_line(90, 2, 1'b1, '0);
    // R3: long line drives the counter into hold
    run_line(4300, 1, 1'b0, '0);
    chk("R3 held clamp", clpob_no, afe_lvl(MAXC, 1'b1, 0, 20));
    // R5 / R7 directed: alternation modes on odd/even, out-of-range select
    for (int a = 0; a < 4; a++) begin
      hblk_alt_i[0] = 2'(a);
      run_line(70, 2, 1'b1, '0);
      run_line(70, 2, 1'b0, '0);
    end
    run_line(70, 2, 1'b1, 4'd12);
    // random lines
    rand_slots();
    for (int n = 0; n < 80; n++) begin
      if (n % 20 == 0) rand_slots();
      run_line($urandom_range(25, 160), $urandom_range(1, 3), 1'(n), 4'($urandom_range(0, 15)));
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule